// File: doc/BRIEF.md
# Shared-Bus Accumulator Processor

This block is an 8-bit stored-program processor. Code and data live in one external memory, and a single bus with a request/acknowledge handshake reaches that memory. The processor holds a program counter, an instruction register, an operand-address latch, a memory-data latch, an accumulator and a carry flag. Every instruction takes two bytes. The first is the opcode and the second is a direct memory address.

A phase sequencer takes each instruction through five named states in a fixed order. `PH_FETCH` reads the opcode at the PC. `PH_DECODE` classifies the opcode and reads the address byte at PC+1. `PH_OPERAND` reads the data byte at the address, but only for ADD and SUB. `PH_EXECUTE` runs the ALU. `PH_WRITE` updates the accumulator, writes memory for STORE, or loads the PC for a jump.

The transitions are as follows:
- Reset enters `PH_FETCH`.
- `PH_FETCH` moves to `PH_DECODE` on acknowledge.
- `PH_DECODE` moves to `PH_OPERAND` on acknowledge. For a HALT or unknown opcode it moves to `PH_HALT` without any bus request.
- `PH_OPERAND` moves to `PH_EXECUTE` on acknowledge, or after one cycle when no data read is needed.
- `PH_EXECUTE` always moves to `PH_WRITE`.
- `PH_WRITE` returns to `PH_FETCH` on acknowledge for STORE, and after one cycle otherwise.
- `PH_HALT` is terminal until reset.

Since there is only one bus, the opcode, address-byte and operand transfers always fall in separate bus phases.

Top module: `acc_cpu`

## Requirements
- R1: Synchronous reset clears the PC, IR, accumulator and carry flag. While reset is held, and again after it is released, the processor requests a read of address 0, with the write strobe low and `halted` low.
- R2: The bus transfers of one instruction occur in this order: opcode read at PC, address-byte read at PC+1, then the data read at the address (ADD/SUB only). At most one transfer is open at a time, and the phases follow the fixed order fetch, decode, operand, execute, write.
- R3: Once `bus_req` is raised, it stays high with `bus_addr` and `bus_we` unchanged until the cycle in which `bus_ack` is high. That cycle completes the transfer. Any number of wait cycles leaves the program results unchanged.
- R4: Opcode 0x73 (ADD) sets the accumulator to (accumulator + mem[addr]) mod 256 and the carry flag to the ninth bit of the sum.
- R5: Opcode 0x74 (SUB) sets the accumulator to (accumulator − mem[addr]) mod 256. The carry flag is set to 1 exactly when mem[addr] exceeds the accumulator (borrow).
- R6: Opcode 0x75 (STORE) performs one bus write of the accumulator to mem[addr] with `bus_we` = 1. It does not read mem[addr].
- R7: Opcode 0x76 (JMP) loads the PC with the address byte, so the next opcode fetch is at that address. It performs no data read.
- R8: After any instruction other than JMP, the PC advances by 2, wrapping modulo 256. An instruction at 0xFE is followed by a fetch at 0x00.
- R9: Opcode 0x00 (HALT), and any opcode other than 0x73–0x76, asserts `halted` after its opcode fetch. No further bus request is raised until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | output | 1 | Transfer request, held until acknowledged |
| bus_we | output | 1 | 1 = write transfer, 0 = read |
| bus_addr | output | 8 | Memory address of the transfer |
| bus_wdata | output | 8 | Write data (accumulator) |
| bus_rdata | input | 8 | Read data, sampled in the acknowledge cycle |
| bus_ack | input | 1 | Transfer acknowledge |
| carry | output | 1 | Carry/borrow flag from the last ADD or SUB |
| halted | output | 1 | High once a HALT or unknown opcode has been fetched |

## Verification
One accumulating program adds 200 and 100. Its wrapped store value 0x2C and its set carry separate modulo arithmetic from saturation or ninth-bit loss. The same program is run with zero and with three wait cycles, which exposes any dependence on acknowledge timing or any change of address before acknowledge. A mixed SUB/ADD/SUB sequence ends in a borrow-free result, while a lone SUB below zero shows the borrow sense of the flag. A program that jumps to 0xFE, rewrites its own first byte and wraps to 0x00 covers the jump target, PC wrap and the shared code/data memory. The recorded transfer order of all three programs shows the phase order, and confirms that STORE and JMP perform no operand read.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [2:0] {
        PH_FETCH   = 3'd0,
        PH_DECODE  = 3'd1,
        PH_OPERAND = 3'd2,
        PH_EXECUTE = 3'd3,
        PH_WRITE   = 3'd4,
        PH_HALT    = 3'd5
    } phase_e;

    localparam logic [7:0] OPC_HALT  = 8'h00;
    localparam logic [7:0] OPC_ADD   = 8'h73;
    localparam logic [7:0] OPC_SUB   = 8'h74;
    localparam logic [7:0] OPC_STORE = 8'h75;
    localparam logic [7:0] OPC_JUMP  = 8'h76;

    // Opcode is one the processor executes (anything else stops it)
    function automatic logic op_known(input logic [7:0] op);
        return (op == OPC_ADD) || (op == OPC_SUB) ||
               (op == OPC_STORE) || (op == OPC_JUMP);
    endfunction

    // Opcode needs a data read in the operand phase
    function automatic logic op_reads_data(input logic [7:0] op);
        return (op == OPC_ADD) || (op == OPC_SUB);
    endfunction

endpackage

// File: rtl/cpu_alu.sv
module cpu_alu #(
    parameter int W = 8
) (
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         c_out
);
    logic [W:0] sum;
    logic [W-1:0] b_mod;

    // One adder serves both operations: b is inverted and 1 carried in for SUB
    always_comb begin
        b_mod = b ^ {W{sub}};
        sum   = {1'b0, a} + {1'b0, b_mod} + {{W{1'b0}}, sub};
        y     = sum[W-1:0];
        // ADD: carry out; SUB: borrow is the inverted carry out
        c_out = sub ? ~sum[W] : sum[W];
    end
endmodule

// File: rtl/cpu_sequencer.sv
module cpu_sequencer
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ack,
    input  logic [7:0] opcode,
    output phase_e     phase
);
    phase_e phase_nx;

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_FETCH;
        else     phase <= phase_nx;
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_FETCH:   if (ack) phase_nx = PH_DECODE;
            PH_DECODE: begin
                if (!op_known(opcode)) phase_nx = PH_HALT;
                else if (ack)          phase_nx = PH_OPERAND;
            end
            PH_OPERAND: begin
                if (!op_reads_data(opcode) || ack) phase_nx = PH_EXECUTE;
            end
            PH_EXECUTE: phase_nx = PH_WRITE;
            PH_WRITE: begin
                if (opcode != OPC_STORE || ack) phase_nx = PH_FETCH;
            end
            PH_HALT:    phase_nx = PH_HALT;
            default:    phase_nx = PH_HALT;
        endcase
    end

    // R2: execute is only ever entered from the operand phase
    a_r2_exec_after_operand: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXECUTE) |-> ($past(phase) == PH_OPERAND));

    // R2: write is only ever entered from execute
    a_r2_write_after_exec: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_WRITE) |-> ($past(phase) == PH_EXECUTE));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              carry,
    output logic              halted
);
    localparam int ADDR_W = DATA_W;
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] PC_ONE  = ADDR_W'(1);

    phase_e            phase;
    logic [ADDR_W-1:0] pc;
    logic [7:0]        ir;
    logic [ADDR_W-1:0] oaddr;
    logic [DATA_W-1:0] mdr;
    logic [DATA_W-1:0] acc;
    logic              carry_q;
    logic [DATA_W-1:0] res;
    logic              res_c;
    logic [DATA_W-1:0] alu_y;
    logic              alu_c;

    cpu_sequencer i_seq (
        .clk    (clk),
        .rst    (rst),
        .ack    (bus_ack),
        .opcode (ir),
        .phase  (phase)
    );

    cpu_alu #(.W(DATA_W)) i_alu (
        .sub   (ir == OPC_SUB),
        .a     (acc),
        .b     (mdr),
        .y     (alu_y),
        .c_out (alu_c)
    );

    // Datapath registers, advanced by phase
    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            ir      <= '0;
            oaddr   <= '0;
            mdr     <= '0;
            acc     <= '0;
            carry_q <= 1'b0;
            res     <= '0;
            res_c   <= 1'b0;
        end else begin
            unique case (phase)
                PH_FETCH:   if (bus_ack) ir <= bus_rdata[7:0];
                PH_DECODE:  if (bus_ack) oaddr <= bus_rdata;
                PH_OPERAND: if (bus_ack && op_reads_data(ir)) mdr <= bus_rdata;
                PH_EXECUTE: begin
                    res   <= alu_y;
                    res_c <= alu_c;
                end
                PH_WRITE: begin
                    if (ir == OPC_JUMP) begin
                        pc <= oaddr;
                    end else if (ir == OPC_STORE) begin
                        if (bus_ack) pc <= pc + PC_STEP;
                    end else begin
                        acc     <= res;
                        carry_q <= res_c;
                        pc      <= pc + PC_STEP;
                    end
                end
                PH_HALT: ;
                default: ;
            endcase
        end
    end

    // Bus outputs, decoded from the phase
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = pc;
        bus_wdata = acc;
        unique case (phase)
            PH_FETCH: begin
                bus_req  = 1'b1;
                bus_addr = pc;
            end
            PH_DECODE: begin
                bus_req  = op_known(ir);
                bus_addr = pc + PC_ONE;
            end
            PH_OPERAND: begin
                bus_req  = op_reads_data(ir);
                bus_addr = oaddr;
            end
            PH_WRITE: begin
                bus_req  = (ir == OPC_STORE);
                bus_we   = (ir == OPC_STORE);
                bus_addr = oaddr;
            end
            PH_EXECUTE: ;
            PH_HALT:    ;
            default:    ;
        endcase
    end

    assign carry  = carry_q;
    assign halted = (phase == PH_HALT);

    // R1: reset leaves architectural state cleared and the sequencer fetching
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc == '0 && acc == '0 && !carry_q && phase == PH_FETCH));

    // R3: an open request holds address and direction until acknowledged
    a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R4: ADD write-back equals the 9-bit sum of the latched operands
    a_r4_add_result: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE && ir == OPC_ADD) |=>
        ({carry_q, acc} == ({1'b0, $past(acc)} + {1'b0, $past(mdr)})));

    // R7: a jump loads the PC with the latched address byte
    a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE && ir == OPC_JUMP) |=> (pc == $past(oaddr)));

    // R8: a completed non-jump instruction moves the PC on by two
    a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE && ir != OPC_JUMP && (ir != OPC_STORE || bus_ack)) |=>
        (pc == ADDR_W'($past(pc) + PC_STEP)));

    // R9: once halted, the bus stays idle
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !bus_req));
endmodule

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
    logic       clk = 1'b0;
    logic       rst;
    logic       bus_req, bus_we, bus_ack, carry, halted;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;

    always #4 clk = ~clk;

    acc_cpu i_acc_cpu (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .carry(carry), .halted(halted)
    );

    int checks = 0;
    int errors = 0;
    int wait_n = 0;
    int viol   = 0;
    int cnt    = 0;
    int tr_n   = 0;
    logic       pend;
    logic [7:0] h_addr;
    logic       h_we;
    logic [7:0] mem     [256];
    logic [7:0] tr_addr [64];
    logic       tr_we   [64];
    logic [7:0] tr_data [64];

    // Memory model: acknowledges after wait_n idle cycles, logs every transfer
    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 1'b0; cnt = 0; pend = 1'b0; tr_n = 0; viol = 0;
            bus_rdata = 8'h00;
        end else if (bus_ack) begin
            bus_ack = 1'b0; cnt = 0; pend = 1'b0;
        end else if (bus_req) begin
            if (pend && (bus_addr != h_addr || bus_we != h_we)) viol++;
            if (!pend) begin pend = 1'b1; h_addr = bus_addr; h_we = bus_we; end
            if (cnt >= wait_n) begin
                bus_ack = 1'b1;
                bus_rdata = mem[bus_addr];
                if (bus_we) mem[bus_addr] = bus_wdata;
                if (tr_n < 64) begin
                    tr_addr[tr_n] = bus_addr;
                    tr_we[tr_n]   = bus_we;
                    tr_data[tr_n] = bus_we ? bus_wdata : mem[bus_addr];
                end
                tr_n++;
            end else cnt++;
        end else if (pend) begin
            viol++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_halt(input string tag);
        int n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " reaches halt"}, halted, 1);
    endtask

    task automatic check_quiet(input string tag);
        int seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_req) seen++;
        end
        chk(tag, seen, 0);
    endtask

    task automatic t_reset();
        clear_mem();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 req in reset", bus_req, 1);
        chk("R1 addr in reset", bus_addr, 0);
        chk("R1 we in reset", bus_we, 0);
        chk("R1 halted in reset", halted, 0);
        chk("R1 carry in reset", carry, 0);
        @(negedge clk);
        rst = 1'b0;
        run_to_halt("R1");
        chk("R1 first fetch at 0", tr_addr[0], 0);
    endtask

    // Program A: ADD 200, ADD 100, STORE, HALT
    task automatic t_add_carry(input int ws);
        clear_mem();
        wait_n = ws;
        mem[0] = 8'h73; mem[1] = 8'h40;
        mem[2] = 8'h73; mem[3] = 8'h41;
        mem[4] = 8'h75; mem[5] = 8'h50;
        mem[6] = 8'h00;
        mem[8'h40] = 8'd200; mem[8'h41] = 8'd100;
        apply_reset();
        run_to_halt("R4");
        chk("R4 wrapped sum stored", mem[8'h50], 8'h2C);
        chk("R4 carry from ninth bit", carry, 1);
        chk("R2 opcode read first", tr_addr[0], 8'h00);
        chk("R2 address byte second", tr_addr[1], 8'h01);
        chk("R2 operand read third", tr_addr[2], 8'h40);
        chk("R8 next fetch at pc+2", tr_addr[3], 8'h02);
        chk("R6 store address", tr_addr[8], 8'h50);
        chk("R6 store is write", tr_we[8], 1);
        chk("R6 store data", tr_data[8], 8'h2C);
        chk("R9 transfer count", tr_n, 10);
        chk("R3 request held stable", viol, 0);
        check_quiet("R9 no request after halt");
    endtask

    // Program B: SUB, ADD, SUB, STORE, unknown opcode
    task automatic t_mixed();
        clear_mem();
        wait_n = 1;
        mem[0] = 8'h74; mem[1] = 8'h40;
        mem[2] = 8'h73; mem[3] = 8'h41;
        mem[4] = 8'h74; mem[5] = 8'h42;
        mem[6] = 8'h75; mem[7] = 8'h50;
        mem[8] = 8'hFF;
        mem[8'h40] = 8'h05; mem[8'h41] = 8'h10; mem[8'h42] = 8'h03;
        apply_reset();
        run_to_halt("R5");
        chk("R5 sub/add/sub result", mem[8'h50], 8'h08);
        chk("R5 no borrow clears carry", carry, 0);
        chk("R9 unknown opcode stops", tr_n, 13);
        chk("R9 last fetch at 8", tr_addr[12], 8'h08);
        check_quiet("R9 quiet after unknown opcode");
    endtask

    // SUB below zero: borrow sets carry
    task automatic t_sub_borrow();
        clear_mem();
        wait_n = 0;
        mem[0] = 8'h74; mem[1] = 8'h40;
        mem[2] = 8'h75; mem[3] = 8'h50;
        mem[4] = 8'h00;
        mem[8'h40] = 8'h05;
        apply_reset();
        run_to_halt("R5");
        chk("R5 0-5 wraps", mem[8'h50], 8'hFB);
        chk("R5 borrow sets carry", carry, 1);
        chk("R6 no read before store", tr_addr[5], 8'h50);
        chk("R6 store write strobe", tr_we[5], 1);
    endtask

    // Program C: JMP 0xFE; STORE acc to 0 (making it HALT); wrap to 0
    task automatic t_jump_wrap();
        clear_mem();
        wait_n = 2;
        mem[0] = 8'h76; mem[1] = 8'hFE;
        mem[8'hFE] = 8'h75; mem[8'hFF] = 8'h00;
        apply_reset();
        mem[0] = 8'h76;
        run_to_halt("R7");
        chk("R7 fetch at jump target", tr_addr[2], 8'hFE);
        chk("R7 no data read", tr_we[2], 0);
        chk("R6 self-modifying write", tr_addr[4], 8'h00);
        chk("R8 pc wraps to 0", tr_addr[5], 8'h00);
        chk("R8 wrapped fetch reads new byte", tr_data[5], 8'h00);
        chk("R7 transfer count", tr_n, 6);
        chk("R3 held with wait states", viol, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        t_reset();
        t_add_carry(0);
        t_add_carry(3);
        t_mixed();
        t_sub_borrow();
        t_jump_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule